// File: doc/BRIEF.md
# Instruction Queue with Branch Lookahead

This block sits between instruction fetch and dispatch. It stores up to six fetched instruction words, each tagged with a flag that marks it as a branch. In any cycle fetch may present a group of one to four words. The group goes in at the tail only if it fits completely. If it does not fit, the group is refused and fetch must hold it.

Two ordered dispatch ports draw non-branch words from the head, as far as the execution-side grants allow. A separate branch port can take the oldest branch-flagged word from any depth in the queue, in the same cycle as the head dispatches. When that happens, the younger words close the gap, so the queue keeps program order. A fetch request output tells fetch when a full-width group would fit. A flush input empties the queue in one cycle after a mispredicted branch.

Top module: `instq_lookahead`

## Requirements
- R1: After reset the queue is empty: both dispatch valids and the branch valid are low, and the fetch request is high.
- R2: A fetch group holds `fill_count_i` words, from 1 to 4. Lane 0 is the oldest, at bits [31:0] of `fill_words_i`, with its branch flag in bit 0 of `fill_branch_i`. `fill_ready_o` is high when no flush is present and the count is no more than the free entries left after this cycle's removals. When `fill_valid_i` and `fill_ready_o` are both high, all lanes are appended behind the words already held, in lane order.
- R3: Dispatch port k (word at bits [32k+31:32k]) is valid exactly when queue positions 0..k are all occupied and none of them is flagged as a branch. Port 0 always shows the oldest word.
- R4: Head dispatches leave in order. A word leaves through port k only when that port is valid, its grant is high, and every lower port also leaves in the same cycle. A grant on port 1 without port 0 removes nothing.
- R5: A branch-flagged word is never shown on a dispatch port. A branch at the head blocks head dispatch until it leaves through the branch port.
- R6: The branch port shows the oldest branch-flagged word at any depth. With `br_grant_i` high, that word leaves in the same cycle as up to two head dispatches, so three words can leave at once. The remaining words keep their program order.
- R7: `fetch_req_o` is high when at least four entries are free after this cycle's removals.
- R8: While `flush_i` is high, every valid output and `fill_ready_o` are low, and nothing is written. In the next cycle the queue is empty.
- R9: The queue never holds more than six words. A refused group leaves the held words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Redirect flush; empties the queue |
| fill_valid_i | input | 1 | Fetch group present |
| fill_count_i | input | 3 | Number of words in the group (1..4) |
| fill_words_i | input | 128 | Group words, lane 0 in the low bits |
| fill_branch_i | input | 4 | Branch flag per lane |
| fill_ready_o | output | 1 | The whole group fits this cycle |
| fetch_req_o | output | 1 | A full four-word group would fit |
| disp_valid_o | output | 2 | Head dispatch port valids |
| disp_words_o | output | 64 | Head dispatch words, port 0 in the low bits |
| disp_grant_i | input | 2 | Execution-side grant per dispatch port |
| br_valid_o | output | 1 | Branch port valid |
| br_word_o | output | 32 | Oldest branch-flagged word |
| br_grant_i | input | 1 | Branch unit accepts the word |

## Verification
Directed sequences fill the queue with groups of one, two and four words. These show that the whole-or-nothing acceptance depends on the free count after this cycle's removals, and not on the count at the start of the cycle. Grant patterns {none, port 1 only, port 0 only, both} separate in-order dispatch from independent per-port draining. Branches are placed at the head, in the middle, at the deepest slot and in pairs. These cases test the oldest-branch choice, head blocking, and gap closing on a three-way removal. A flush arriving together with a fill, and a long pseudo-random mix of all inputs checked against a reference queue, cover how the paths interact.

// File: rtl/iq_pkg.sv
// Package: shared defaults and a helper for the instruction queue.
// Assumes: nothing beyond standard SystemVerilog.
package iq_pkg;
    localparam int unsigned IQ_DEPTH_DEF   = 6;
    localparam int unsigned IQ_FILL_DEF    = 4;
    localparam int unsigned IQ_ISSUE_DEF   = 2;
    localparam int unsigned IQ_WORD_W_DEF  = 32;

    // Free entries that remain once removals are counted; a flush frees all.
    function automatic int unsigned free_after(input int unsigned depth,
                                               input int unsigned held,
                                               input int unsigned removed,
                                               input logic        flush);
        if (flush) return depth;
        return depth - held + removed;
    endfunction
endpackage

// File: rtl/iq_head_select.sv
// Module: head dispatch selector.
// It offers queue positions 0..ISSUE_W-1 to the dispatch ports in order.
// Each port needs every lower position to be a held non-branch word.
// A word leaves only when its port and all lower ports are granted.
// Assumes: ISSUE_W <= DEPTH and the occupied positions are 0..cnt_i-1.
module iq_head_select #(
    parameter int unsigned DEPTH   = 6,
    parameter int unsigned ISSUE_W = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [DEPTH-1:0]   br_flags_i,
    input  logic               hold_i,
    input  logic [ISSUE_W-1:0] grant_i,
    output logic [ISSUE_W-1:0] slot_valid_o,
    output logic [ISSUE_W-1:0] take_o,
    output logic [CNT_W-1:0]   n_take_o
);
    // Walk the head positions: validity and grants both chain in order.
    always_comb begin
        logic ok;
        logic go;
        ok       = !hold_i;
        go       = 1'b1;
        n_take_o = '0;
        for (int k = 0; k < int'(ISSUE_W); k++) begin
            ok              = ok && (k < int'(cnt_i)) && !br_flags_i[k];
            slot_valid_o[k] = ok;
            go              = go && ok && grant_i[k];
            take_o[k]       = go;
            if (go) n_take_o = n_take_o + CNT_W'(1);
        end
    end

    // Contiguity of valids and removals across the ports.
    for (genvar k = 1; k < int'(ISSUE_W); k++) begin : g_order_chk
        assert_valid_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid_o[k] |-> slot_valid_o[k-1]);
        assert_take_in_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
            take_o[k] |-> take_o[k-1]);
    end
endmodule

// File: rtl/iq_branch_pick.sv
// Module: lookahead branch picker.
// It finds the oldest branch-flagged word among the held positions and
// offers it to the branch port.
// Assumes: the occupied positions are 0..cnt_i-1.
module iq_branch_pick #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [DEPTH-1:0] br_flags_i,
    input  logic             hold_i,
    input  logic             grant_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             take_o
);
    // Priority search from the tail down, so the lowest index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        idx_o = '0;
        for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
            if ((i < int'(cnt_i)) && br_flags_i[i]) begin
                found = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
        valid_o = found && !hold_i;
        take_o  = valid_o && grant_i;
    end

    // The offered branch must lie within the held region.
    assert_pick_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (idx_o < IDX_W'(cnt_i)));
endmodule

// File: rtl/iq_compact.sv
// Module: queue next-state compactor.
// It moves the surviving words to the front in their existing order, then
// appends the accepted fetch lanes behind them. A clear empties everything.
// Assumes: the caller accepts a group only when it fits.
module iq_compact #(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned FILL_W = 4,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned FCNT_W = 3
) (
    input  logic [DEPTH-1:0][WORD_W-1:0]  words_i,
    input  logic [DEPTH-1:0]              br_i,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [DEPTH-1:0]              drop_i,
    input  logic                          clear_i,
    input  logic                          add_i,
    input  logic [FCNT_W-1:0]             add_cnt_i,
    input  logic [FILL_W-1:0][WORD_W-1:0] add_words_i,
    input  logic [FILL_W-1:0]             add_br_i,
    output logic [DEPTH-1:0][WORD_W-1:0]  words_o,
    output logic [DEPTH-1:0]              br_o,
    output logic [CNT_W-1:0]              cnt_o
);
    // Squeeze out dropped positions, then append the new lanes.
    always_comb begin
        int pos;
        words_o = '0;
        br_o    = '0;
        pos     = 0;
        if (!clear_i) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if ((i < int'(cnt_i)) && !drop_i[i]) begin
                    words_o[IDX_W'(pos)] = words_i[i];
                    br_o[IDX_W'(pos)]    = br_i[i];
                    pos                  = pos + 1;
                end
            end
            if (add_i) begin
                for (int j = 0; j < int'(FILL_W); j++) begin
                    if ((j < int'(add_cnt_i)) && (pos < int'(DEPTH))) begin
                        words_o[IDX_W'(pos)] = add_words_i[j];
                        br_o[IDX_W'(pos)]    = add_br_i[j];
                        pos                  = pos + 1;
                    end
                end
            end
        end
        cnt_o = CNT_W'(pos);
    end
endmodule

// File: rtl/instq_lookahead.sv
// Module: instruction queue with branch lookahead (top).
// It holds DEPTH fetched words with branch flags. In one cycle it can
// release up to ISSUE_W non-branch words from the head, plus the oldest
// branch from any depth, and accept a whole fetch group at the tail.
// Assumes: fill_count_i lies in 1..FILL_W when fill_valid_i is high.
module instq_lookahead
    import iq_pkg::*;
#(
    parameter int unsigned WORD_W  = IQ_WORD_W_DEF,
    parameter int unsigned DEPTH   = IQ_DEPTH_DEF,
    parameter int unsigned FILL_W  = IQ_FILL_DEF,
    parameter int unsigned ISSUE_W = IQ_ISSUE_DEF,
    localparam int unsigned FCNT_W = $clog2(FILL_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       fill_valid_i,
    input  logic [FCNT_W-1:0]          fill_count_i,
    input  logic [FILL_W*WORD_W-1:0]   fill_words_i,
    input  logic [FILL_W-1:0]          fill_branch_i,
    output logic                       fill_ready_o,
    output logic                       fetch_req_o,
    output logic [ISSUE_W-1:0]         disp_valid_o,
    output logic [ISSUE_W*WORD_W-1:0]  disp_words_o,
    input  logic [ISSUE_W-1:0]         disp_grant_i,
    output logic                       br_valid_o,
    output logic [WORD_W-1:0]          br_word_o,
    input  logic                       br_grant_i
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][WORD_W-1:0]  word_q, word_d;
    logic [DEPTH-1:0]              brf_q, brf_d;
    logic [CNT_W-1:0]              cnt_q, cnt_d;
    logic [ISSUE_W-1:0]            head_take;
    logic [CNT_W-1:0]              head_n;
    logic [IDX_W-1:0]              br_idx;
    logic                          br_take;
    logic [DEPTH-1:0]              drop;
    logic                          add_group;
    logic [FILL_W-1:0][WORD_W-1:0] fill_lanes;

    assign fill_lanes = fill_words_i;

    iq_head_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .CNT_W(CNT_W)) head_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt_q),
        .br_flags_i   (brf_q),
        .hold_i       (flush_i),
        .grant_i      (disp_grant_i),
        .slot_valid_o (disp_valid_o),
        .take_o       (head_take),
        .n_take_o     (head_n)
    );

    iq_branch_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) brpick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_q),
        .br_flags_i (brf_q),
        .hold_i     (flush_i),
        .grant_i    (br_grant_i),
        .valid_o    (br_valid_o),
        .idx_o      (br_idx),
        .take_o     (br_take)
    );

    // Present the head words on the dispatch ports.
    for (genvar k = 0; k < int'(ISSUE_W); k++) begin : g_disp_word
        assign disp_words_o[k*WORD_W +: WORD_W] = word_q[k];
    end

    assign br_word_o = word_q[br_idx];

    // Mark every position that leaves this cycle.
    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            drop[i] = (i < int'(head_n)) || (br_take && (int'(br_idx) == i));
        end
    end

    // Space after removals decides fetch request and group acceptance.
    always_comb begin
        int unsigned space;
        space        = free_after(DEPTH, int'(cnt_q),
                                  int'(head_n) + int'(br_take), flush_i);
        fetch_req_o  = space >= FILL_W;
        fill_ready_o = !flush_i && (fill_count_i != '0) &&
                       (int'(fill_count_i) <= int'(FILL_W)) &&
                       (int'(fill_count_i) <= int'(space));
        add_group    = fill_valid_i && fill_ready_o;
    end

    iq_compact #(
        .DEPTH(DEPTH), .FILL_W(FILL_W), .WORD_W(WORD_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W), .FCNT_W(FCNT_W)
    ) compact_i (
        .words_i     (word_q),
        .br_i        (brf_q),
        .cnt_i       (cnt_q),
        .drop_i      (drop),
        .clear_i     (flush_i),
        .add_i       (add_group),
        .add_cnt_i   (fill_count_i),
        .add_words_i (fill_lanes),
        .add_br_i    (fill_branch_i),
        .words_o     (word_d),
        .br_o        (brf_d),
        .cnt_o       (cnt_d)
    );

    // Queue storage: count and flags reset, words load from the compactor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            brf_q  <= '0;
            word_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            brf_q  <= brf_d;
            word_q <= word_d;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    assert_refused_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && !fill_ready_o && !flush_i) |=> (cnt_q <= $past(cnt_q)));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (!fill_ready_o && !br_valid_o && (disp_valid_o == '0)));
    assert_accept_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && fill_ready_o) |=> (cnt_q >= CNT_W'($past(fill_count_i))));
    assert_req_means_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !flush_i && (fill_count_i != '0) &&
         (int'(fill_count_i) <= int'(FILL_W))) |-> fill_ready_o);
endmodule

// File: tb/instq_lookahead_tb.sv
`timescale 1ns/1ps
module instq_lookahead_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic         fill_valid_i = 1'b0;
    logic [2:0]   fill_count_i = '0;
    logic [127:0] fill_words_i = '0;
    logic [3:0]   fill_branch_i = '0;
    logic         fill_ready_o;
    logic         fetch_req_o;
    logic [1:0]   disp_valid_o;
    logic [63:0]  disp_words_o;
    logic [1:0]   disp_grant_i = '0;
    logic         br_valid_o;
    logic [31:0]  br_word_o;
    logic         br_grant_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int next_id  = 1;

    int          m_cnt = 0;
    logic [31:0] m_w [6];
    bit          m_b [6];

    always #10 clk = ~clk;

    instq_lookahead dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .fill_valid_i(fill_valid_i), .fill_count_i(fill_count_i),
        .fill_words_i(fill_words_i), .fill_branch_i(fill_branch_i),
        .fill_ready_o(fill_ready_o), .fetch_req_o(fetch_req_o),
        .disp_valid_o(disp_valid_o), .disp_words_o(disp_words_o),
        .disp_grant_i(disp_grant_i), .br_valid_o(br_valid_o),
        .br_word_o(br_word_o), .br_grant_i(br_grant_i)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Build a group of fc fresh words; flags given per lane.
    task automatic make_group(input int fc, output logic [127:0] w);
        w = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < fc) begin
                w[j*32 +: 32] = 32'hC000_0000 | next_id;
                next_id++;
            end
        end
    endtask

    // One cycle: drive, compare against the reference queue, advance.
    task automatic step(input string tag, input bit fv, input int fc,
                        input logic [127:0] fw, input logic [3:0] fb,
                        input logic [1:0] g, input bit bg, input bit fl);
        bit dv0, dv1, bv, t0, t1, bt, rdy;
        int bi, free, k;
        logic [31:0] nw [6];
        bit          nb [6];
        @(negedge clk);
        fill_valid_i = fv; fill_count_i = 3'(fc); fill_words_i = fw;
        fill_branch_i = fb; disp_grant_i = g; br_grant_i = bg; flush_i = fl;
        #1;
        dv0 = !fl && m_cnt >= 1 && !m_b[0];
        dv1 = dv0 && m_cnt >= 2 && !m_b[1];
        bi = -1;
        for (int i = 0; i < m_cnt; i++) if (m_b[i] && bi < 0) bi = i;
        bv = !fl && bi >= 0;
        check(disp_valid_o == {dv1, dv0}, {tag, " R3/R5 disp_valid"},
              64'(disp_valid_o), 64'({dv1, dv0}));
        if (dv0) check(disp_words_o[31:0] == m_w[0], {tag, " R3 port0 word"},
                       64'(disp_words_o[31:0]), 64'(m_w[0]));
        if (dv1) check(disp_words_o[63:32] == m_w[1], {tag, " R3 port1 word"},
                       64'(disp_words_o[63:32]), 64'(m_w[1]));
        check(br_valid_o == bv, {tag, " R6 br_valid"}, 64'(br_valid_o), 64'(bv));
        if (bv) check(br_word_o == m_w[bi], {tag, " R6 br_word"},
                      64'(br_word_o), 64'(m_w[bi]));
        t0 = dv0 && g[0];
        t1 = t0 && dv1 && g[1];
        bt = bv && bg;
        free = fl ? 6 : 6 - m_cnt + int'(t0) + int'(t1) + int'(bt);
        check(fetch_req_o == (free >= 4), {tag, " R7 fetch_req"},
              64'(fetch_req_o), 64'(free >= 4));
        rdy = !fl && fc >= 1 && fc <= 4 && fc <= free;
        check(fill_ready_o == rdy, {tag, " R2 fill_ready"}, 64'(fill_ready_o), 64'(rdy));
        k = 0;
        if (!fl) begin
            for (int i = 0; i < m_cnt; i++) begin
                if (!((i == 0 && t0) || (i == 1 && t1) || (bt && i == bi))) begin
                    nw[k] = m_w[i]; nb[k] = m_b[i]; k++;
                end
            end
            if (fv && rdy) begin
                for (int j = 0; j < fc; j++) begin
                    nw[k] = fw[j*32 +: 32]; nb[k] = fb[j]; k++;
                end
            end
        end
        for (int i = 0; i < k; i++) begin m_w[i] = nw[i]; m_b[i] = nb[i]; end
        m_cnt = k;
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 0, '0, '0, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic fill(input string tag, input int fc, input logic [3:0] fb,
                        input logic [1:0] g, input bit bg);
        logic [127:0] w;
        make_group(fc, w);
        step(tag, 1'b1, fc, w, fb, g, bg, 1'b0);
    endtask

    task automatic clear_q(input string tag);
        step(tag, 1'b0, 0, '0, '0, 2'b00, 1'b0, 1'b1);
    endtask

    // R1: empty queue right after reset.
    task automatic t_reset;
        @(negedge clk);
        #1;
        check(disp_valid_o == 2'b00, "R1 disp_valid after reset", 64'(disp_valid_o), 64'd0);
        check(br_valid_o == 1'b0, "R1 br_valid after reset", 64'(br_valid_o), 64'd0);
        check(fetch_req_o == 1'b1, "R1 fetch_req after reset", 64'(fetch_req_o), 64'd1);
    endtask

    // R2/R9: fill to capacity, refuse, then accept once dispatch frees room.
    task automatic t_capacity;
        fill("R2", 4, 4'b0000, 2'b00, 1'b0);
        fill("R2", 2, 4'b0000, 2'b00, 1'b0);
        fill("R9", 1, 4'b0000, 2'b00, 1'b0);
        check(m_cnt == 6, "R9 reference holds six", 64'(m_cnt), 64'd6);
        fill("R9", 3, 4'b0000, 2'b11, 1'b0);
        fill("R2", 2, 4'b0000, 2'b11, 1'b0);
        idle("R9");
    endtask

    // R4: grant patterns on a queue of plain words.
    task automatic t_grants;
        clear_q("R8");
        fill("R4", 4, 4'b0000, 2'b00, 1'b0);
        step("R4", 1'b0, 0, '0, '0, 2'b10, 1'b0, 1'b0);
        step("R4", 1'b0, 0, '0, '0, 2'b01, 1'b0, 1'b0);
        step("R4", 1'b0, 0, '0, '0, 2'b11, 1'b0, 1'b0);
        idle("R4");
    endtask

    // R5/R6: branches at the head, mid-queue, deepest slot, and in pairs.
    task automatic t_branches;
        clear_q("R8");
        fill("R6", 4, 4'b0100, 2'b00, 1'b0);
        step("R6", 1'b0, 0, '0, '0, 2'b11, 1'b1, 1'b0);
        idle("R6");
        clear_q("R8");
        fill("R5", 3, 4'b0101, 2'b00, 1'b0);
        step("R5", 1'b0, 0, '0, '0, 2'b11, 1'b0, 1'b0);
        step("R5", 1'b0, 0, '0, '0, 2'b11, 1'b1, 1'b0);
        step("R5", 1'b0, 0, '0, '0, 2'b11, 1'b1, 1'b0);
        idle("R5");
        clear_q("R8");
        fill("R6", 4, 4'b0000, 2'b00, 1'b0);
        fill("R6", 2, 4'b0010, 2'b00, 1'b0);
        step("R6", 1'b0, 0, '0, '0, 2'b11, 1'b1, 1'b0);
        idle("R6");
        step("R6", 1'b0, 0, '0, '0, 2'b11, 1'b0, 1'b0);
        idle("R6");
    endtask

    // R8: flush with a fill in the same cycle, then confirm the queue is empty.
    task automatic t_flush;
        fill("R8", 4, 4'b1000, 2'b00, 1'b0);
        begin
            logic [127:0] w;
            make_group(2, w);
            step("R8", 1'b1, 2, w, 4'b0000, 2'b11, 1'b1, 1'b1);
        end
        idle("R8");
        check(m_cnt == 0, "R8 reference empty", 64'(m_cnt), 64'd0);
    endtask

    // Pseudo-random mix checked against the reference queue.
    task automatic t_mix;
        logic [31:0] r = 32'h1357_9BDF;
        for (int n = 0; n < 300; n++) begin
            logic [127:0] w;
            int fc;
            r = r * 32'd1664525 + 32'd1013904223;
            fc = int'(r[9:8]) + 1;
            make_group(fc, w);
            step("R6 mix", r[20], fc, w, r[27:24], r[13:12], r[15], r[31:27] == 5'd3);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capacity();
        t_grants();
        t_branches();
        t_flush();
        t_mix();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule